// File: doc/BRIEF.md
# I2C Indexed Block Register Target

This block is an I2C target that exposes a small bank of 8-bit configuration registers. Every transfer is indexed and carries a length: a write names a starting register, then a byte count, then exactly that many data bytes, which land in consecutive registers. A read first points the index with a short write (address byte, index byte), then issues a repeated start with the read address. The target answers with a count byte taken from a programmable count register, then streams register contents from the index onward.

SCL and SDA are brought into the system clock domain through two-flop synchronizers and edge-detected there. SDA is driven open-drain: `sda_oe` high means pull the line low. The whole bank is visible in parallel on `cfg_o`, and one register holds, in its low bits, a read-only copy of strap inputs captured right after reset. The I2C bus gives the target no way to stall, so the block has no back-pressure. Each write lands in the bank one system clock after the SCL falling edge that ends its data byte.

Top module: `ixb_i2c_target`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte gets SDA released in the ninth clock, and the target then ignores the bus until the next start.
- R2: A write is 0xD2, an index byte (its low log2(NREG) bits pick the register), a count byte X, then X data bytes stored at consecutive registers. The target ACKs every one of these bytes.
- R3: Data bytes beyond the count X are NACKed and change no register.
- R4: The index advances by one after each data byte, written or read, and wraps from NREG-1 to 0.
- R5: After an index write, a repeated start and 0xD3, the target sends the count register value first. It then sends the registers from the index onward, each byte MSB first.
- R6: The count register sits at index 8 and resets to 0x0F. Its value is the number of register bytes a read returns after the count byte. Bytes the host requests beyond that read as 0xFF, because SDA is left released.
- R7: A host NACK ends a read. The target keeps SDA released until the next start.
- R8: In register 5, bits 4:0 read back the strap inputs captured after reset, and writes to those bits are ignored. Bits 7:5 are ordinary read/write bits.
- R9: A start or stop that arrives in the middle of a byte aborts the transfer without touching any register. After a start the target expects a fresh address byte.
- R10: After reset SDA is released, every register reads 0x00 except the count register (0x0F) and the strap bits, and `cfg_o` shows this state.
- R11: The target changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | STRAP_W | Strap levels captured after reset |
| cfg_o | output | NREG*8 | All register contents, register g at bits g*8+7:g*8 |

## Verification
A wrong protocol state shows at the ports within one byte time. The host sees an ACK or NACK on the wrong ninth clock, or a data bit that differs from the register model, or a target that keeps driving SDA after the NACK. A wrong index or a wrong count shows as a misplaced byte on `cfg_o` one system clock after the byte, or as a wrong byte in the read stream at the wrapping point or at the count boundary. An abort that is not honoured leaves a modified register on `cfg_o` right after the stop.

// File: rtl/ixb_pkg.sv
`timescale 1ns/1ps
package ixb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } link_st_e;

  typedef enum logic [2:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_READ
  } phase_e;
endpackage

// File: rtl/ixb_line_sync.sv
`timescale 1ns/1ps
module ixb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/ixb_reg_bank.sv
`timescale 1ns/1ps
module ixb_reg_bank #(
  parameter int          NREG      = 16,
  parameter int          IW        = 4,
  parameter int          CNT_IDX   = 8,
  parameter logic [7:0]  CNT_RST   = 8'h0F,
  parameter int          STRAP_IDX = 5,
  parameter int          STRAP_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [IW-1:0]        rd_idx,
  input  logic [STRAP_W-1:0]   strap_i,
  output logic [7:0]           rd_data,
  output logic [7:0]           cnt_val,
  output logic [NREG*8-1:0]    cfg_o
);
  logic [NREG-1:0][7:0] view;
  logic [STRAP_W-1:0]   strap_q;
  logic                 strap_taken;

  // strap levels are taken once, in the first cycle after reset (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q     <= '0;
      strap_taken <= 1'b0;
    end else if (!strap_taken) begin
      strap_q     <= strap_i;
      strap_taken <= 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == STRAP_IDX) begin : g_strap
      logic [7-STRAP_W:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            hi_q <= '0;
        else if (wr_en && wr_idx == IW'(g))    hi_q <= wr_data[7:STRAP_W];
      end
      assign view[g] = {hi_q, strap_q};
    end else begin : g_plain
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= (g == CNT_IDX) ? CNT_RST : 8'h00;
        else if (wr_en && wr_idx == IW'(g))    q <= wr_data;
      end
      assign view[g] = q;
    end
    assign cfg_o[g*8 +: 8] = view[g];
  end

  assign rd_data = view[rd_idx];
  assign cnt_val = view[CNT_IDX];

  assert_strap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_taken && $past(strap_taken)) |-> $stable(strap_q));

  assert_count_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == IW'(CNT_IDX)) |=> $stable(cnt_val));
endmodule

// File: rtl/ixb_link_fsm.sv
`timescale 1ns/1ps
module ixb_link_fsm
  import ixb_pkg::*;
#(
  parameter int         IW       = 4,
  parameter logic [6:0] TGT_ADDR = 7'h69
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    cnt_val,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [IW-1:0] ptr
);
  link_st_e   state;
  phase_e     phase;
  logic [2:0] bit_cnt;
  logic [7:0] sh;
  logic       byte_full;
  logic [7:0] wleft;
  logic [7:0] rleft;
  logic [7:0] tx;
  logic       host_ack;
  logic       rx_ack;

  always_comb begin
    unique case (phase)
      PH_ADDR:  rx_ack = (sh[7:1] == TGT_ADDR);          // R1
      PH_INDEX: rx_ack = 1'b1;
      PH_COUNT: rx_ack = 1'b1;
      PH_WDATA: rx_ack = (wleft != 8'd0);                // R3
      default:  rx_ack = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bit_cnt   <= '0;
      sh        <= '0;
      byte_full <= 1'b0;
      ptr       <= '0;
      wleft     <= '0;
      rleft     <= '0;
      tx        <= '0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin                                 // R9
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        byte_full <= 1'b0;
      end else if (start_det) begin                       // R9
        state     <= ST_RX;
        phase     <= PH_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && !byte_full) begin
              sh      <= {sh[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              if (rx_ack) begin
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end else begin
                state  <= ST_IDLE;
              end
              unique case (phase)
                PH_ADDR: if (rx_ack) phase <= sh[0] ? PH_READ : PH_INDEX;
                PH_INDEX: begin
                  ptr   <= sh[IW-1:0];
                  phase <= PH_COUNT;
                end
                PH_COUNT: begin
                  wleft <= sh;
                  phase <= PH_WDATA;
                end
                PH_WDATA: if (wleft != 8'd0) begin       // R2, R4
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + 1'b1;
                  wleft   <= wleft - 8'd1;
                end
                default: ;
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (phase == PH_READ) begin                 // R5: count byte first
                tx     <= cnt_val;
                rleft  <= cnt_val;
                sda_oe <= ~cnt_val[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                tx      <= {tx[6:0], 1'b0};
                sda_oe  <= ~tx[6];
                bit_cnt <= bit_cnt + 3'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) host_ack <= ~sda_lvl;
            if (scl_fall) begin
              if (host_ack) begin
                bit_cnt <= '0;
                state   <= ST_TX;
                if (rleft != 8'd0) begin                  // R4, R6
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[7];
                  ptr    <= ptr + 1'b1;
                  rleft  <= rleft - 8'd1;
                end else begin
                  tx     <= 8'hFF;
                  sda_oe <= 1'b0;
                end
              end else begin
                state <= ST_IDLE;                         // R7
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_sda_hold_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

  assert_write_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall));

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  assert_index_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == {IW{1'b1}}) |-> (ptr == '0));
endmodule

// File: rtl/ixb_i2c_target.sv
`timescale 1ns/1ps
module ixb_i2c_target #(
  parameter int          NREG        = 16,
  parameter logic [6:0]  TGT_ADDR    = 7'h69,
  parameter int          CNT_IDX     = 8,
  parameter logic [7:0]  CNT_RST     = 8'h0F,
  parameter int          STRAP_IDX   = 5,
  parameter int          STRAP_W     = 5,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [STRAP_W-1:0]  strap_i,
  output logic [NREG*8-1:0]   cfg_o
);
  localparam int IW = $clog2(NREG);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [IW-1:0] wr_idx, ptr;
  logic [7:0]    wr_data, rd_data, cnt_val;

  ixb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ixb_link_fsm #(.IW(IW), .TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .cnt_val(cnt_val), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ptr(ptr)
  );

  ixb_reg_bank #(
    .NREG(NREG), .IW(IW), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST),
    .STRAP_IDX(STRAP_IDX), .STRAP_W(STRAP_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(ptr), .strap_i(strap_i), .rd_data(rd_data), .cnt_val(cnt_val), .cfg_o(cfg_o)
  );
endmodule

// File: tb/ixb_i2c_target_tb_top.sv
`timescale 1ns/1ps
module ixb_i2c_target_tb_top;
  localparam int NREG = 16;
  localparam int Q    = 40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              scl_low = 1'b0, sda_low = 1'b0;
  logic              dut_oe;
  logic [4:0]        strap = 5'b10110;
  logic [NREG*8-1:0] cfg;
  wire               scl_bus = ~scl_low;
  wire               sda_bus = ~(sda_low | dut_oe);

  ixb_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .sda_oe(dut_oe), .strap_i(strap), .cfg_o(cfg)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m [NREG];
  logic [7:0] exp_q[$], rx_q[$];
  string      tag_q[$];

  task automatic ck(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] mvec();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m[i];
    return v;
  endfunction

  task automatic i2c_start();
    sda_low = 1'b0; #Q; scl_low = 1'b0; #Q; sda_low = 1'b1; #Q; scl_low = 1'b1; #Q;
  endtask
  task automatic i2c_stop();
    sda_low = 1'b1; #Q; scl_low = 1'b0; #Q; sda_low = 1'b0; #Q;
  endtask
  task automatic write_bit(input bit b);
    sda_low = ~b; #Q; scl_low = 1'b0; #(2*Q); scl_low = 1'b1; #Q;
  endtask
  task automatic read_bit(output bit b);
    sda_low = 1'b0; #Q; scl_low = 1'b0; #Q; b = sda_bus; #Q; scl_low = 1'b1; #Q;
  endtask
  task automatic write_byte(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) write_bit(v[i]);
    read_bit(s);
    ack = ~s;
  endtask
  task automatic read_byte(output logic [7:0] v, input bit last);
    bit s;
    for (int i = 7; i >= 0; i--) begin read_bit(s); v[i] = s; end
    write_bit(last);
  endtask

  // model update for a stored byte: strap bits of register 5 never change (R8)
  task automatic model_store(input int idx, input logic [7:0] d);
    if (idx == 5) m[5] = {d[7:5], strap};
    else          m[idx] = d;
  endtask

  // R2 R3 R4: full indexed write; data bytes past cnt expect NACK
  task automatic wr_txn(input logic [7:0] idx, input logic [7:0] cnt, input logic [7:0] d[$]);
    bit a;
    i2c_start();
    write_byte(8'hD2, a);  ck(a, "R2 addr ack", a, 1);
    write_byte(idx, a);    ck(a, "R2 index ack", a, 1);
    write_byte(cnt, a);    ck(a, "R2 count ack", a, 1);
    for (int i = 0; i < d.size(); i++) begin
      write_byte(d[i], a);
      if (i < cnt) begin
        ck(a == 1'b1, "R2 data ack", a, 1);
        model_store((idx[3:0] + i) % NREG, d[i]);
      end else begin
        ck(a == 1'b0, "R3 extra byte nack", a, 0);
      end
    end
    i2c_stop();
    #(2*Q);
  endtask

  // R5 R6 R4: expected read stream from the model
  task automatic exp_read(input logic [7:0] idx, input int n, input string tag);
    exp_q.push_back(m[8]); tag_q.push_back({tag, " count byte"});
    for (int k = 1; k < n; k++) begin
      if (k <= m[8]) exp_q.push_back(m[(idx[3:0] + k - 1) % NREG]);
      else           exp_q.push_back(8'hFF);
      tag_q.push_back(tag);
    end
  endtask

  task automatic rd_txn(input logic [7:0] idx, input int n);
    bit a;
    logic [7:0] v;
    i2c_start();
    write_byte(8'hD2, a); ck(a, "R5 addr ack", a, 1);
    write_byte(idx, a);   ck(a, "R5 index ack", a, 1);
    i2c_start();
    write_byte(8'hD3, a); ck(a, "R1 read addr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(v, k == n - 1);
      rx_q.push_back(v);
    end
    i2c_stop();
    #(2*Q);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (rx_q.size() > 0) begin
        logic [7:0] v;
        v = rx_q.pop_front();
        if (exp_q.size() == 0) ck(1'b0, "R5 unexpected byte", v, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          ck(v == e, t, v, e);
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit a, s, all_one;
    logic [7:0] v;
    for (int i = 0; i < NREG; i++) m[i] = 8'h00;
    m[8] = 8'h0F;
    m[5] = {3'b000, strap};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    ck(dut_oe == 1'b0, "R10 sda released", dut_oe, 0);
    ck(cfg == mvec(), "R10 R8 reset contents", cfg, mvec());

    // R2 plain write
    wr_txn(8'h02, 8'd3, '{8'hA1, 8'hB2, 8'hC3});
    ck(cfg == mvec(), "R2 write contents", cfg, mvec());

    // R5 R4 R6 read of default length 15, wraps past register 15
    exp_read(8'h02, 16, "R5 R4 read");
    rd_txn(8'h02, 16);

    // R6 program count register to 2, read near top of bank
    wr_txn(8'h08, 8'd1, '{8'h02});
    ck(cfg == mvec(), "R6 count written", cfg, mvec());
    exp_read(8'h0E, 3, "R6 short read");
    rd_txn(8'h0E, 3);

    // R4 write wrap
    wr_txn(8'h0F, 8'd2, '{8'h11, 8'h22});
    ck(cfg == mvec(), "R4 write wraps", cfg, mvec());

    // R6 bytes past count read as FF
    exp_read(8'h00, 4, "R6 past count");
    rd_txn(8'h00, 4);

    // R3 extra data byte
    wr_txn(8'h0A, 8'd1, '{8'h33, 8'h44});
    ck(cfg == mvec(), "R3 extra not stored", cfg, mvec());

    // R8 strap bits ignore writes
    wr_txn(8'h05, 8'd1, '{8'hFF});
    ck(cfg[5*8 +: 8] == {3'b111, strap}, "R8 strap readback", cfg[5*8 +: 8], {3'b111, strap});

    // R1 foreign address
    i2c_start();
    write_byte(8'hA4, a);
    ck(a == 1'b0, "R1 foreign addr nack", a, 0);
    write_byte(8'h00, a);
    ck(a == 1'b0, "R1 ignored after nack", a, 0);
    i2c_stop();
    #(2*Q);
    ck(cfg == mvec(), "R1 no change", cfg, mvec());

    // R7 host nack ends read
    exp_q.push_back(m[8]); tag_q.push_back("R7 count byte");
    i2c_start();
    write_byte(8'hD2, a);
    write_byte(8'h03, a);
    i2c_start();
    write_byte(8'hD3, a);
    read_byte(v, 1'b1);
    rx_q.push_back(v);
    all_one = 1'b1;
    for (int k = 0; k < 9; k++) begin read_bit(s); all_one &= s; end
    ck(all_one, "R7 released after nack", all_one, 1);
    i2c_stop();
    #(2*Q);

    // R9 stop in the middle of a data byte
    i2c_start();
    write_byte(8'hD2, a);
    write_byte(8'h0C, a);
    write_byte(8'h01, a);
    write_bit(1'b0); write_bit(1'b1); write_bit(1'b0); write_bit(1'b1);
    i2c_stop();
    #(2*Q);
    ck(cfg == mvec(), "R9 mid-byte stop no write", cfg, mvec());

    // R9 start in the middle of an address byte, then a clean write
    i2c_start();
    write_bit(1'b1); write_bit(1'b1); write_bit(1'b0);
    i2c_start();
    write_byte(8'hD2, a); ck(a, "R9 resync addr ack", a, 1);
    write_byte(8'h0C, a);
    write_byte(8'h01, a);
    write_byte(8'h77, a); ck(a, "R9 resync data ack", a, 1);
    i2c_stop();
    #(2*Q);
    m[12] = 8'h77;
    ck(cfg == mvec(), "R9 write after resync", cfg, mvec());
    ck(dut_oe == 1'b0, "R11 bus released at end", dut_oe, 0);

    repeat (10) @(negedge clk);
    ck(exp_q.size() == 0, "R5 all bytes received", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule